// File: doc/BRIEF.md
# Column-Parallel Pixel Frame Sequencer

This block drives one frame capture on a pixel array of NX columns by NY rows. Each pixel holds two stored levels, a reference and a signal, and each column has its own 5-bit converter at its foot. After a frame start pulse the sequencer runs a fixed series of phases with one strobe per phase: array reset, reference store, integration, signal store, row-by-row conversion and serial readout.

During conversion it selects the rows one at a time in ascending order. All column converters report for the selected row in that same cycle. The sequencer forms the correlated-double-sampling result for every column in parallel and writes the whole row into an on-chip frame buffer of NX×NY words.

During readout it drains the buffer one 5-bit word per clock, row-major, with a valid flag and a last-word flag. Idle cycles separate frames. A synchronous reset aborts any frame in progress.

Top module: `pix_readout_seq`

## Requirements
- R1: After reset, and at any time no frame is running, all phase strobes, `row_sel`, `out_valid` and `out_last` are 0. The sequencer leaves idle only on a clock edge where `frame_start` is 1.
- R2: The edge that captures `frame_start` starts the phase series. Let the cycle after that edge be cycle 0. Then `rst_strb` is high for cycle 0 and `sref_strb` for cycle 1. `int_strb` is high for cycles 2 to T_INT+1. `ssig_strb` is high for cycle T_INT+2. `conv_strb` is high for cycles T_INT+3 to T_INT+2+NY.
- R3: In the k-th conversion cycle (k = 0..NY-1), `row_sel` is one-hot with bit k set, so rows are visited 0 first, ascending. Outside conversion `row_sel` is 0.
- R4: Each stored word is the column's signal code minus its reference code, read from `col_sig` and `col_ref` in the cycle its row is selected. Column c occupies bits [5c+4:5c] of each bus. When the reference code exceeds the signal code, the word is 0.
- R5: Readout emits exactly NX×NY words on consecutive cycles, from cycle T_INT+4+NY onward, with `out_valid` high. The order is row-major: word j is row j/NX, column j mod NX.
- R6: `out_last` is high together with the final word of the frame only.
- R7: A `frame_start` pulse while a frame is in progress has no effect: the running frame keeps its timing and data, and no second frame follows.
- R8: A synchronous `rst` in the middle of a frame returns the block to idle at the next edge, with all outputs 0, and a later `frame_start` captures a complete fresh frame.
- R9: Back-to-back frames overwrite the buffer, so each readout carries only the data converted in its own frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse that begins a frame when idle |
| col_sig | input | NX*5 | Per-column signal-level codes from the converters |
| col_ref | input | NX*5 | Per-column reference-level codes from the converters |
| rst_strb | output | 1 | Array reset phase strobe |
| sref_strb | output | 1 | Reference-level store strobe |
| int_strb | output | 1 | Integration phase strobe |
| ssig_strb | output | 1 | Signal-level store strobe |
| conv_strb | output | 1 | Conversion phase strobe |
| row_sel | output | NY | One-hot row select during conversion |
| out_valid | output | 1 | Output word valid |
| out_data | output | 5 | Pixel word |
| out_last | output | 1 | Final word of the frame |

## Verification
The bench checks every phase strobe and `row_sel` against the exact cycle numbers above. An off-by-one in the integration counter or in the row counter therefore shows up as a shifted or stretched strobe. It also shows up as a readout that starts a cycle early or late.

The converter patterns include columns whose reference code exceeds the signal code, and also the full-scale extremes. A design that wraps the subtraction instead of clamping it returns large words where 0 is expected. Swapped row and column terms in the buffer address produce words out of row-major order.

Further cases cover a start pulse arriving mid-frame, which a careless design treats as a restart or as a second queued frame. A reset arriving mid-frame must leave every output quiet.

// File: rtl/pix_seq_pkg.sv
package pix_seq_pkg;

    localparam int SAMPLE_W = 5;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RST   = 3'd1,
        PH_SREF  = 3'd2,
        PH_INTEG = 3'd3,
        PH_SSIG  = 3'd4,
        PH_CONV  = 3'd5,
        PH_READ  = 3'd6
    } phase_e;

    typedef struct packed {
        logic rst_s;
        logic sref_s;
        logic int_s;
        logic ssig_s;
        logic conv_s;
    } strobes_t;

    // Correlated double sampling result, floored at zero.
    function automatic sample_t cds_diff(input sample_t sig, input sample_t refl);
        return (sig >= refl) ? sample_t'(sig - refl) : '0;
    endfunction

    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pix_phase_ctrl.sv
module pix_phase_ctrl
    import pix_seq_pkg::*;
#(
    parameter int NX    = 4,
    parameter int NY    = 3,
    parameter int T_INT = 4,
    localparam int NPIX = NX * NY,
    localparam int MAXC = (T_INT > NPIX) ? T_INT : NPIX,
    localparam int CW   = safe_clog2(MAXC + 1),
    localparam int RW   = safe_clog2(NY),
    localparam int AW   = safe_clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    output strobes_t      strb,
    output logic [NY-1:0] row_sel,
    output logic          wr_en,
    output logic [RW-1:0] wr_row,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr
);

    phase_e        state_q;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
        end else begin
            unique case (state_q)
                PH_IDLE: if (frame_start) state_q <= PH_RST;
                PH_RST:  state_q <= PH_SREF;
                PH_SREF: begin
                    state_q <= PH_INTEG;
                    cnt_q   <= '0;
                end
                PH_INTEG: begin
                    if (cnt_q == CW'(T_INT - 1)) begin
                        state_q <= PH_SSIG;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_SSIG: begin
                    state_q <= PH_CONV;
                    row_q   <= '0;
                end
                PH_CONV: begin
                    if (row_q == RW'(NY - 1)) begin
                        state_q <= PH_READ;
                        row_q   <= '0;
                        cnt_q   <= '0;
                    end else begin
                        row_q <= row_q + 1'b1;
                    end
                end
                PH_READ: begin
                    if (cnt_q == CW'(NPIX - 1)) begin
                        state_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        strb.rst_s  = (state_q == PH_RST);
        strb.sref_s = (state_q == PH_SREF);
        strb.int_s  = (state_q == PH_INTEG);
        strb.ssig_s = (state_q == PH_SSIG);
        strb.conv_s = (state_q == PH_CONV);
        wr_en       = (state_q == PH_CONV);
        wr_row      = row_q;
        rd_en       = (state_q == PH_READ);
        rd_addr     = cnt_q[AW-1:0];
    end

    for (genvar r = 0; r < NY; r++) begin : g_rowsel
        assign row_sel[r] = (state_q == PH_CONV) && (row_q == RW'(r));
    end

    // R3
    row_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel));

    // R2
    sref_to_int_chk: assert property (@(posedge clk) disable iff (rst)
        strb.sref_s |=> strb.int_s);

    // R2
    ssig_to_conv_chk: assert property (@(posedge clk) disable iff (rst)
        strb.ssig_s |=> (strb.conv_s && row_sel[0]));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_IDLE && !frame_start) |=> (state_q == PH_IDLE));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_CONV && row_q != RW'(NY - 1)) |=> (state_q == PH_CONV));

endmodule

// File: rtl/pix_cds_bank.sv
module pix_cds_bank
    import pix_seq_pkg::*;
#(
    parameter int NX = 4,
    localparam int BW = NX * SAMPLE_W
) (
    input  logic [BW-1:0] col_sig,
    input  logic [BW-1:0] col_ref,
    output logic [BW-1:0] row_word
);

    for (genvar c = 0; c < NX; c++) begin : g_col
        sample_t s_c, r_c;
        assign s_c = col_sig[c*SAMPLE_W +: SAMPLE_W];
        assign r_c = col_ref[c*SAMPLE_W +: SAMPLE_W];
        assign row_word[c*SAMPLE_W +: SAMPLE_W] = cds_diff(s_c, r_c);
    end

endmodule

// File: rtl/pix_frame_buf.sv
module pix_frame_buf
    import pix_seq_pkg::*;
#(
    parameter int NX = 4,
    parameter int NY = 3,
    localparam int NPIX = NX * NY,
    localparam int RW   = safe_clog2(NY),
    localparam int AW   = safe_clog2(NPIX),
    localparam int BW   = NX * SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  logic [BW-1:0] wr_word,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          out_valid,
    output sample_t       out_data,
    output logic          out_last
);

    sample_t mem [NPIX];

    for (genvar c = 0; c < NX; c++) begin : g_wr
        always_ff @(posedge clk) begin
            if (wr_en)
                mem[AW'(int'(wr_row) * NX + c)] <= wr_word[c*SAMPLE_W +: SAMPLE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= rd_en;
            out_data  <= rd_en ? mem[rd_addr] : '0;
            out_last  <= rd_en && (rd_addr == AW'(NPIX - 1));
        end
    end

    // R6
    last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R5
    stream_gapless_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    // R6
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !out_valid);

endmodule

// File: rtl/pix_readout_seq.sv
module pix_readout_seq
    import pix_seq_pkg::*;
#(
    parameter int NX    = 4,
    parameter int NY    = 3,
    parameter int T_INT = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_start,
    input  logic [NX*SAMPLE_W-1:0]   col_sig,
    input  logic [NX*SAMPLE_W-1:0]   col_ref,
    output logic                     rst_strb,
    output logic                     sref_strb,
    output logic                     int_strb,
    output logic                     ssig_strb,
    output logic                     conv_strb,
    output logic [NY-1:0]            row_sel,
    output logic                     out_valid,
    output logic [SAMPLE_W-1:0]      out_data,
    output logic                     out_last
);

    localparam int NPIX = NX * NY;
    localparam int RW   = safe_clog2(NY);
    localparam int AW   = safe_clog2(NPIX);
    localparam int BW   = NX * SAMPLE_W;

    strobes_t      strb;
    logic          wr_en, rd_en;
    logic [RW-1:0] wr_row;
    logic [AW-1:0] rd_addr;
    logic [BW-1:0] row_word;

    pix_phase_ctrl #(.NX(NX), .NY(NY), .T_INT(T_INT)) u_ctrl (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .strb(strb), .row_sel(row_sel),
        .wr_en(wr_en), .wr_row(wr_row),
        .rd_en(rd_en), .rd_addr(rd_addr)
    );

    pix_cds_bank #(.NX(NX)) u_cds (
        .col_sig(col_sig), .col_ref(col_ref), .row_word(row_word)
    );

    pix_frame_buf #(.NX(NX), .NY(NY)) u_buf (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_row(wr_row), .wr_word(row_word),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    assign rst_strb  = strb.rst_s;
    assign sref_strb = strb.sref_s;
    assign int_strb  = strb.int_s;
    assign ssig_strb = strb.ssig_s;
    assign conv_strb = strb.conv_s;

endmodule

// File: tb/pix_readout_seq_bench.sv
module pix_readout_seq_bench;

    localparam int NX    = 4;
    localparam int NY    = 3;
    localparam int T_INT = 4;
    localparam int W     = 5;
    localparam int NPIX  = NX * NY;
    localparam int C_CONV = T_INT + 3;
    localparam int C_OUT  = T_INT + 4 + NY;
    localparam int C_END  = C_OUT + NPIX + 4;

    // Vector table: pattern seed and cycle of a spurious start (-1 = none).
    localparam int NVEC = 6;
    localparam int VSEED [NVEC] = '{3, 10, 99, 98, 21, 7};
    localparam int VSPUR [NVEC] = '{-1, -1, -1, 5, 9, C_OUT + 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic [NX*W-1:0] col_sig, col_ref;
    logic rst_strb, sref_strb, int_strb, ssig_strb, conv_strb;
    logic [NY-1:0] row_sel;
    logic out_valid, out_last;
    logic [W-1:0] out_data;

    int seed = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pix_readout_seq #(.NX(NX), .NY(NY), .T_INT(T_INT)) u_pix_readout_seq (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .col_sig(col_sig), .col_ref(col_ref),
        .rst_strb(rst_strb), .sref_strb(sref_strb), .int_strb(int_strb),
        .ssig_strb(ssig_strb), .conv_strb(conv_strb), .row_sel(row_sel),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    function automatic int sig_of(int s, int r, int c);
        if (s == 99) return 31;
        if (s == 98) return 0;
        return (s * 7 + r * 5 + c * 3) % 32;
    endfunction

    function automatic int ref_of(int s, int r, int c);
        if (s == 99) return 0;
        if (s == 98) return 31;
        return (s * 3 + r + c * 11) % 32;
    endfunction

    function automatic int exp_word(int s, int r, int c);
        int a = sig_of(s, r, c);
        int b = ref_of(s, r, c);
        return (a >= b) ? a - b : 0;
    endfunction

    // Behavioural column converters: answer for the selected row.
    always_comb begin
        int r;
        r = 0;
        for (int k = 0; k < NY; k++) if (row_sel[k]) r = k;
        for (int c = 0; c < NX; c++) begin
            col_sig[c*W +: W] = W'(sig_of(seed, r, c));
            col_ref[c*W +: W] = W'(ref_of(seed, r, c));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic all_quiet(input string req);
        chk({rst_strb, sref_strb, int_strb, ssig_strb, conv_strb, row_sel,
             out_valid, out_last} == '0, req,
            int'({rst_strb, sref_strb, int_strb, ssig_strb, conv_strb, row_sel,
                  out_valid, out_last}), 0);
    endtask

    // One frame: start pulse, then per-cycle comparison at the falling edge.
    task automatic run_frame(input int s, input int spur);
        int bad_ph, bad_row, bad_word, bad_last, bad_val;
        bad_ph = 0; bad_row = 0; bad_word = 0; bad_last = 0; bad_val = 0;
        seed = s;
        @(negedge clk);
        frame_start = 1'b1;
        for (int k = 0; k <= C_END; k++) begin
            @(negedge clk);
            frame_start = (k == spur);
            // R2 phase strobes
            if (rst_strb  != (k == 0)) bad_ph++;
            if (sref_strb != (k == 1)) bad_ph++;
            if (int_strb  != (k >= 2 && k <= T_INT + 1)) bad_ph++;
            if (ssig_strb != (k == T_INT + 2)) bad_ph++;
            if (conv_strb != (k >= C_CONV && k < C_CONV + NY)) bad_ph++;
            // R3 row order
            if (k >= C_CONV && k < C_CONV + NY) begin
                if (row_sel != NY'(1 << (k - C_CONV))) bad_row++;
            end else if (row_sel != '0) bad_row++;
            // R5, R4, R9, R6 readout stream
            if (k >= C_OUT && k < C_OUT + NPIX) begin
                int j = k - C_OUT;
                int e = exp_word(s, j / NX, j % NX);
                if (!out_valid) bad_val++;
                if (int'(out_data) != e) begin
                    bad_word++;
                    $display("FAIL R4 word %0d seed %0d actual=%0d expected=%0d",
                             j, s, out_data, e);
                end
                if (out_last != (j == NPIX - 1)) bad_last++;
            end else begin
                if (out_valid) bad_val++;
                if (out_last) bad_last++;
            end
        end
        frame_start = 1'b0;
        chk(bad_ph == 0, "R2 phase strobe timing", bad_ph, 0);
        chk(bad_row == 0, "R3 row select order", bad_row, 0);
        chk(bad_val == 0, "R5 valid window", bad_val, 0);
        chk(bad_word == 0, "R4/R9 cds words row-major", bad_word, 0);
        chk(bad_last == 0, "R6 last flag", bad_last, 0);
        if (spur >= 0) chk(bad_ph + bad_val == 0, "R7 mid-frame start ignored", bad_ph + bad_val, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state and idle without a start pulse
        all_quiet("R1 reset state");
        repeat (6) @(negedge clk);
        all_quiet("R1 idle without start");

        // Table walk: several patterns, clamp and full-scale cases, spurious starts (R7),
        // back-to-back frames reusing the buffer (R9).
        for (int v = 0; v < NVEC; v++) run_frame(VSEED[v], VSPUR[v]);

        // R8 reset mid-frame during conversion
        seed = 5;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (C_CONV) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        all_quiet("R8 outputs cleared after reset");
        repeat (C_END) begin
            @(negedge clk);
            if (rst_strb || out_valid) chk(1'b0, "R8 no frame resumes", 1, 0);
        end
        chk(!rst_strb && !out_valid, "R8 stays idle", int'(rst_strb), 0);

        // R8 reset during readout, then a fresh frame
        seed = 12;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (C_OUT + 2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        all_quiet("R8 readout aborted");
        run_frame(17, -1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule